// File: doc/BRIEF.md
# Grouped Maskable Interrupt Controller

This block collects interrupt sources in sets of four and presents a single prioritised request to a processor core. Each set owns two byte-wide control registers. The low register records which sources have fired (pending) and which of those have been latched as live requests (detect). The high register holds a four-bit per-source enable mask and a three-bit priority level for the whole set. Periodic timer expiry pulses land in the first sets, one timer per slot. Four external interrupt lines share one dedicated set.

When a source fires, its pending flag is set. The detect flags of its set then absorb the AND of the enable mask and the updated pending flags. Any set with a detect flag raised competes for the processor. The highest level wins, and equal levels go to the lower set index. The winning set is reported as its one-based number shifted left by one, together with its level, so that the core can load the level into its status word. A global enable input from the core gates the request. Software acknowledges an interrupt by writing the low register of the set, which overwrites both nibbles.

Top module: `grouped_irq_ctrl`

## Requirements
- R1: Reset clears every low and high register to zero and deasserts the request.
- R2: Register address 2g selects the low register of set g: pending flags in bits 7:4, detect flags in bits 3:0. A write replaces the whole byte. Address 2g+1 selects the high register: enable mask in bits 3:0, level in bits 6:4. Bit 7 of a high register always reads 0. Reads return the addressed register combinationally.
- R3: A pulse on timer input t sets pending bit (t mod 4) of set t/4, and a pulse on external line k sets pending bit k of the dedicated set (index 7 by default). A pulse that coincides with a write to the same low register is merged on top of the written value, so the pulse is not lost.
- R4: In a cycle with at least one source pulse in a set, that set's detect flags become detect OR (enable AND new pending). In a cycle with no pulse in the set, a change of the enable mask leaves detect unchanged.
- R5: Detect and pending flags are cleared only by a write to their low register or by reset.
- R6: The request output is high exactly when global enable is high and at least one set has a nonzero detect nibble.
- R7: The level output carries the level field of the winning set. The winner is the requesting set with the highest level, and ties go to the lowest set index.
- R8: The group code output equals (winning set index + 1) shifted left by one. Timers t report code ((t/4)+1)*2, and the external lines report code 16.
- R9: While the request is low, the level and group code outputs are zero.
- R10: Once raised, the request stays high while global enable is high until a low-register write clears the winner's detect flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register address: set index in the upper bits, bit 0 selects high (1) or low (0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the addressed register |
| timer_tick | input | NUM_TIMERS (10) | One-cycle timer expiry pulses |
| ext_irq | input | 4 | One-cycle external interrupt pulses |
| global_en | input | 1 | Processor-side interrupt enable |
| irq_req | output | 1 | Interrupt request to the core |
| irq_level | output | 3 | Level of the winning set |
| irq_code | output | CODE_W (8) | Winning set number shifted left by one |

## Verification
The hardest situations to reach are the ones where the order of events matters. One is an enable mask written after a source has already gone pending, which must not raise detect until a later pulse lands in the same set. The other is a pulse arriving in the very cycle that software overwrites the low register. Directed sequences build both on purpose, and they also build a level tie between a timer set and the external set. A long random phase then mixes sparse pulses, random register writes and toggling of the global enable, so that acknowledges race against new events, while a behavioural model is compared on every clock.

// File: rtl/girq_pkg.sv
package girq_pkg;
  localparam int unsigned SLOTS = 4;
  localparam int unsigned LVL_W = 3;

  typedef logic [SLOTS-1:0] slot_t;

  // Detect flags absorb enabled pending flags only in a cycle with a source event.
  function automatic slot_t detect_update(slot_t det, slot_t en, slot_t pend, logic evt);
    return evt ? (det | (en & pend)) : det;
  endfunction

  // One-based set number, shifted left by one.
  function automatic int unsigned group_code(int unsigned idx);
    return (idx + 1) << 1;
  endfunction
endpackage

// File: rtl/girq_group.sv
module girq_group
  import girq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_lo,
  input  logic       wr_hi,
  input  logic [7:0] wdata,
  input  slot_t      src,
  output logic [7:0] lo_q,
  output logic [6:0] hi_q,
  output logic       src_evt
);
  logic [7:0] base;
  slot_t      pend_n;
  slot_t      det_n;

  always_comb begin
    base    = wr_lo ? wdata : lo_q;
    src_evt = |src;
    pend_n  = base[7:4] | src;
    det_n   = detect_update(base[3:0], hi_q[3:0], pend_n, src_evt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= {pend_n, det_n};
      if (wr_hi) hi_q <= wdata[6:0];
    end
  end
endmodule

// File: rtl/girq_arbiter.sv
module girq_arbiter
  import girq_pkg::*;
#(
  parameter int NG    = 8,
  localparam int IDX_W = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic [NG-1:0]            active,
  input  logic [NG-1:0][LVL_W-1:0] lvl,
  output logic                     valid,
  output logic [IDX_W-1:0]         win_idx,
  output logic [LVL_W-1:0]         win_lvl
);
  always_comb begin
    valid   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    for (int g = 0; g < NG; g++) begin
      // strict compare: an equal level never displaces a lower index
      if (active[g] && (!valid || lvl[g] > win_lvl)) begin
        valid   = 1'b1;
        win_idx = IDX_W'(g);
        win_lvl = lvl[g];
      end
    end
  end
endmodule

// File: rtl/grouped_irq_ctrl.sv
module grouped_irq_ctrl
  import girq_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int NUM_TIMERS = 10,
  parameter int EXT_GROUP  = 7,
  parameter int CODE_W     = 8,
  localparam int GIDX_W    = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int ADDR_W    = GIDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [NUM_TIMERS-1:0] timer_tick,
  input  logic [SLOTS-1:0]  ext_irq,
  input  logic              global_en,
  output logic              irq_req,
  output logic [LVL_W-1:0]  irq_level,
  output logic [CODE_W-1:0] irq_code
);
  logic [NUM_GROUPS-1:0][7:0]       grp_lo;
  logic [NUM_GROUPS-1:0][6:0]       grp_hi;
  logic [NUM_GROUPS-1:0]            src_evt;
  logic [NUM_GROUPS-1:0]            grp_active;
  logic [NUM_GROUPS-1:0][LVL_W-1:0] grp_lvl;
  logic                             arb_valid;
  logic [GIDX_W-1:0]                win_idx;
  logic [LVL_W-1:0]                 win_lvl;
  logic [GIDX_W-1:0]                rd_sel;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_set
    slot_t src;
    logic  wr_lo, wr_hi;

    for (genvar b = 0; b < SLOTS; b++) begin : g_slot
      localparam int T = g * SLOTS + b;
      logic tmr_bit, ext_bit;
      if (T < NUM_TIMERS) begin : g_tmr
        assign tmr_bit = timer_tick[T];
      end else begin : g_no_tmr
        assign tmr_bit = 1'b0;
      end
      if (g == EXT_GROUP) begin : g_ext
        assign ext_bit = ext_irq[b];
      end else begin : g_no_ext
        assign ext_bit = 1'b0;
      end
      assign src[b] = tmr_bit | ext_bit;
    end

    assign wr_lo = reg_wr && (reg_addr == ADDR_W'(2 * g));
    assign wr_hi = reg_wr && (reg_addr == ADDR_W'(2 * g + 1));

    girq_group u_group (
      .clk     (clk),
      .rst     (rst),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .wdata   (reg_wdata),
      .src     (src),
      .lo_q    (grp_lo[g]),
      .hi_q    (grp_hi[g]),
      .src_evt (src_evt[g])
    );

    assign grp_active[g] = |grp_lo[g][3:0];
    assign grp_lvl[g]    = grp_hi[g][6:4];
  end

  girq_arbiter #(.NG(NUM_GROUPS)) u_arb (
    .active  (grp_active),
    .lvl     (grp_lvl),
    .valid   (arb_valid),
    .win_idx (win_idx),
    .win_lvl (win_lvl)
  );

  assign rd_sel = reg_addr[ADDR_W-1:1];

  always_comb begin
    reg_rdata = '0;
    if (int'(rd_sel) < NUM_GROUPS)
      reg_rdata = reg_addr[0] ? {1'b0, grp_hi[rd_sel]} : grp_lo[rd_sel];
  end

  assign irq_req   = global_en && arb_valid;
  assign irq_level = irq_req ? win_lvl : '0;
  assign irq_code  = irq_req ? CODE_W'(group_code(32'(win_idx))) : '0;
endmodule

// File: rtl/girq_checker.sv
module girq_checker #(
  parameter int NUM_GROUPS = 8,
  parameter int NUM_TIMERS = 10,
  parameter int CODE_W     = 8,
  parameter int ADDR_W     = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       reg_wr,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [NUM_TIMERS-1:0]      timer_tick,
  input logic                       global_en,
  input logic                       irq_req,
  input logic [2:0]                 irq_level,
  input logic [CODE_W-1:0]          irq_code,
  input logic [NUM_GROUPS-1:0][7:0] grp_lo,
  input logic [NUM_GROUPS-1:0][6:0] grp_hi
);
  logic wr_lo0;
  assign wr_lo0 = reg_wr && (reg_addr == '0);

  a_r1_reset_clear: assert property (@(posedge clk) $fell(rst) |-> (grp_lo == '0 && grp_hi == '0 && !irq_req));

  a_r6_gate: assert property (@(posedge clk) disable iff (rst) !global_en |-> !irq_req);

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> (irq_level == '0 && irq_code == '0));

  a_r8_code_range: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_code[0] == 1'b0 && irq_code >= CODE_W'(2) && irq_code <= CODE_W'(2 * NUM_GROUPS)));

  a_r3_timer0_pending: assert property (@(posedge clk) disable iff (rst)
    timer_tick[0] |=> grp_lo[0][4]);

  a_r4_timer0_detect: assert property (@(posedge clk) disable iff (rst)
    (timer_tick[0] && grp_hi[0][0] && !reg_wr) |=> grp_lo[0][0]);

  a_r5_detect_sticky: assert property (@(posedge clk) disable iff (rst)
    (grp_lo[0][0] && !wr_lo0) |=> grp_lo[0][0]);

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_req && !reg_wr) |=> (irq_req || !global_en));
endmodule

bind grouped_irq_ctrl girq_checker #(
  .NUM_GROUPS (NUM_GROUPS),
  .NUM_TIMERS (NUM_TIMERS),
  .CODE_W     (CODE_W),
  .ADDR_W     (ADDR_W)
) u_girq_checker (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .timer_tick (timer_tick),
  .global_en  (global_en),
  .irq_req    (irq_req),
  .irq_level  (irq_level),
  .irq_code   (irq_code),
  .grp_lo     (grp_lo),
  .grp_hi     (grp_hi)
);

// File: tb/test_grouped_irq_ctrl.sv
module test_grouped_irq_ctrl;
  localparam int NG = 8;
  localparam int NT = 10;
  localparam int XG = 7;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [NT-1:0] timer_tick = '0;
  logic [3:0] ext_irq = '0;
  logic       global_en = 1'b0;
  logic       irq_req;
  logic [2:0] irq_level;
  logic [7:0] irq_code;

  int checks = 0;
  int errors = 0;
  int m_lo[NG];
  int m_hi[NG];
  bit g_rst = 1'b1;
  bit g_en  = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  grouped_irq_ctrl i_grouped_irq_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timer_tick(timer_tick),
    .ext_irq(ext_irq), .global_en(global_en), .irq_req(irq_req),
    .irq_level(irq_level), .irq_code(irq_code)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: one update per rising edge.
  task automatic model_edge(input bit wr, input int addr, input int wd, input int tmr, input int ext);
    int nlo[NG];
    if (g_rst) begin
      for (int g = 0; g < NG; g++) begin m_lo[g] = 0; m_hi[g] = 0; end
      return;
    end
    for (int g = 0; g < NG; g++) begin
      int s = 0;
      int base = (wr && addr == 2 * g) ? wd : m_lo[g];
      for (int b = 0; b < 4; b++)
        if (4 * g + b < NT && ((tmr >> (4 * g + b)) & 1) != 0) s |= (1 << b);
      if (g == XG) s |= ext;
      if (s != 0) begin
        int p = ((base >> 4) | s) & 15;
        int d = (base & 15) | (m_hi[g] & 15 & p);
        nlo[g] = (p << 4) | d;
      end else nlo[g] = base;
    end
    for (int g = 0; g < NG; g++) begin
      m_lo[g] = nlo[g];
      if (wr && addr == 2 * g + 1) m_hi[g] = wd & 8'h7f;
    end
  endtask

  task automatic compare();
    int eg = -1;
    int el = 0;
    int a = int'(reg_addr);
    for (int lv = 7; lv >= 0 && eg < 0; lv--)
      for (int g = 0; g < NG && eg < 0; g++)
        if ((m_lo[g] & 15) != 0 && ((m_hi[g] >> 4) & 7) == lv) begin eg = g; el = lv; end
    if (!g_en || eg < 0) begin
      chk("R6 irq_req", int'(irq_req), 0);
      chk("R9 irq_level", int'(irq_level), 0);
      chk("R9 irq_code", int'(irq_code), 0);
    end else begin
      chk("R6 irq_req", int'(irq_req), 1);
      chk("R7 irq_level", int'(irq_level), el);
      chk("R8 irq_code", int'(irq_code), (eg + 1) * 2);
    end
    chk("R2 reg_rdata", int'(reg_rdata), (a % 2 == 1) ? m_hi[a / 2] : m_lo[a / 2]);
  endtask

  task automatic step(input bit wr, input int addr, input int wd, input int tmr, input int ext);
    @(negedge clk);
    rst        = g_rst;
    global_en  = g_en;
    reg_wr     = wr;
    reg_addr   = 4'(addr);
    reg_wdata  = 8'(wd);
    timer_tick = NT'(tmr);
    ext_irq    = 4'(ext);
    @(posedge clk);
    model_edge(wr, addr, wd, tmr, ext);
    #1;
    compare();
  endtask

  task automatic rd(input int addr);
    step(1'b0, addr, 0, 0, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    g_rst = 1'b0;
    rd(0);
    chk("R1 reset low", int'(reg_rdata), 0);
    rd(15);
    chk("R1 reset high", int'(reg_rdata), 0);

    // R2: register layout and readback
    step(1, 1, 8'hB1, 0, 0);
    rd(1);
    chk("R2 high bit7 reads 0", int'(reg_rdata), 8'h31);
    step(1, 0, 8'hA5, 0, 0);
    rd(0);
    chk("R2 low overwrite", int'(reg_rdata), 8'hA5);
    step(1, 0, 8'h00, 0, 0);

    // R3/R4: timer 0 -> set 0 bit 0
    g_en = 1'b1;
    step(0, 0, 0, 1, 0);
    chk("R3 R4 set0 low", int'(reg_rdata), 8'h11);
    chk("R8 timer0 code", int'(irq_code), 2);
    chk("R7 timer0 level", int'(irq_level), 3);

    g_en = 1'b0;
    rd(0);
    chk("R6 gated off", int'(irq_req), 0);
    chk("R9 gated code", int'(irq_code), 0);
    g_en = 1'b1;

    // R7: timer 5 -> set 1 bit 1 at level 5
    step(1, 3, 8'h52, 0, 0);
    step(0, 2, 0, 1 << 5, 0);
    chk("R3 set1 low", int'(reg_rdata), 8'h22);
    chk("R7 higher level wins", int'(irq_code), 4);

    // R7 tie: external line 2 at level 5 in set 7
    step(1, 15, 8'h54, 0, 0);
    step(0, 14, 0, 0, 4'b0100);
    chk("R3 ext low", int'(reg_rdata), 8'h44);
    chk("R7 tie lower index", int'(irq_code), 4);

    // R10: hold with no writes
    for (int i = 0; i < 5; i++) rd(2);
    chk("R10 held", int'(irq_code), 4);
    step(1, 2, 0, 0, 0);
    chk("R8 R10 ext code after ack", int'(irq_code), 16);

    // R4: enable written after pending, no event
    step(1, 5, 8'h60, 0, 0);
    step(0, 4, 0, 1 << 9, 0);
    chk("R4 pending only", int'(reg_rdata), 8'h20);
    step(1, 5, 8'h62, 0, 0);
    rd(4);
    chk("R4 no event no detect", int'(reg_rdata), 8'h20);
    step(0, 4, 0, 1 << 8, 0);
    chk("R4 event latches", int'(reg_rdata), 8'h32);
    chk("R7 level6 wins", int'(irq_code), 6);

    // R3: pulse coincides with low write
    step(1, 4, 8'h00, 1 << 8, 0);
    rd(4);
    chk("R3 merged pulse", int'(reg_rdata), 8'h10);
    chk("R5 R10 back to ext", int'(irq_code), 16);
    rd(14);
    chk("R5 ext sticky", int'(reg_rdata), 8'h44);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit wr = ($urandom % 4 == 0);
      int tm = int'($urandom & $urandom & $urandom) & ((1 << NT) - 1);
      int ex = int'($urandom & $urandom & $urandom) & 15;
      if ($urandom % 16 == 0) g_en = ~g_en;
      step(wr, int'($urandom % 16), int'($urandom % 256), tm, ex);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule